// File: doc/BRIEF.md
# Halt-Mode Debug Control Unit

This block lets an external debugger stop a processor core, advance it one instruction at a time, and let it run again. It also moves values into and out of the core's register file. The debugger reaches the block over a small peripheral bus. The bus holds four 32-bit words: a control/status word, a transfer-select word (write-only), a transfer-data word, and a monitor-control word. Toward the core the block drives a level halt request and a one-cycle step grant, and it samples the core's halted indication. Register transfers use a request/acknowledge pair.

The bits fall into two reset domains. A power-on reset clears everything. A system reset, or a vector-reset request from the core, clears only the halt-request bit and the monitor trap field. This lets a debugger keep debug enabled across a warm reset of the core.

Top module: `halt_debug_unit`

## Requirements
- R1: Word offsets are fixed: 0x00 control/status, 0x04 transfer-select (write-only, reads 0), 0x08 transfer-data, 0x0C monitor-control. Reads are combinational on `bus_rdata` while `bus_sel` is 1 and `bus_wr` is 0.
- R2: Power-on reset clears every register. The control/status word, the monitor-control word and the transfer-data word all read 0.
- R3: Control/status bit 0 is debug-enable, bit 1 halt-request, bit 2 step, bit 3 interrupt-mask and bit 5 stall-snapshot, all stored as written. `core_halt_req` is 1 exactly while the stored enable and halt-request bits are both 1.
- R4: A write whose bit 0 is 0 stores halt-request as 0, so halt-request never reads back 1 while debug-enable is 0.
- R5: Control/status bit 17 is a read-only halted flag. It equals `core_halted` delayed by one clock, so it sets one cycle after the core halts and clears one cycle after the core leaves the halted state.
- R6: `core_step` pulses high for exactly one cycle after a control/status write with bit 0 = 1, bit 2 = 1 and bit 1 = 0, issued while halt-request was 1 and the halted flag was 1. No other write produces a pulse.
- R7: A write to the transfer-select word starts a transfer. Bit 16 gives the direction (1 = write into the core register) and bits 4:0 give the index. `core_xfer_req` stays high and control/status bit 16 (ready) stays 0 until `core_xfer_ack`.
- R8: On `core_xfer_ack` the request drops and ready becomes 1. For a read transfer, the transfer-data word then holds `core_xfer_rdata`. For a write transfer, `core_xfer_wdata` carries the transfer-data word.
- R9: `sys_rst` or `vec_rst_req` clears only halt-request in the control/status word. Bits 0, 2, 3, 5 and ready keep their values, and a bus write in that cycle is dropped.
- R10: Monitor-control bits 19:16 are cleared by system or vector reset. Bits 0 and 24 are cleared only by power-on reset. All other bits read 0.
- R11: Reads at unmapped or misaligned offsets return 0, and writes there change nothing. Writes to read-only fields (bits 16 and 17 of control/status) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| vec_rst_req | input | 1 | Vector-reset request from the core |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| core_halted | input | 1 | Core reports it is halted |
| core_halt_req | output | 1 | Halt request to the core |
| core_step | output | 1 | One-cycle single-step grant |
| core_xfer_req | output | 1 | Register transfer pending |
| core_xfer_wr | output | 1 | Transfer direction, 1 = write into the core |
| core_xfer_idx | output | IDX_W | Core register index |
| core_xfer_wdata | output | 32 | Value for a write transfer |
| core_xfer_rdata | input | 32 | Value returned by a read transfer |
| core_xfer_ack | input | 1 | Core completes the transfer |

## Verification
The bench uses the defaults ADDR_W = 5 and IDX_W = 5. A 5-bit offset reaches past the four mapped words, so reads and writes at 0x14 and at a misaligned offset can be checked to see that they return zero and are dropped. A 5-bit index lets the bench drive index values 3 and 7 and check them at the core-side pins. It also checks the full halt, step, re-halt and resume sequence against a bench-driven halted line, and runs both warm-reset sources against the power-on reset.

// File: rtl/hdbg_pkg.sv
package hdbg_pkg;

    localparam int DW = 32;

    // word offsets (bus_addr[3:2])
    typedef enum logic [1:0] {
        WORD_CTRL = 2'd0,
        WORD_SEL  = 2'd1,
        WORD_DATA = 2'd2,
        WORD_MON  = 2'd3
    } word_e;

    // control/status bit positions
    localparam int B_EN     = 0;
    localparam int B_HALT   = 1;
    localparam int B_STEP   = 2;
    localparam int B_MASK   = 3;
    localparam int B_SNAP   = 5;
    localparam int B_READY  = 16;
    localparam int B_HALTED = 17;

    // transfer-select direction bit
    localparam int B_DIR = 16;

    // monitor-control field masks
    localparam logic [DW-1:0] MON_WARM_MASK = 32'h000F_0000;
    localparam logic [DW-1:0] MON_COLD_MASK = 32'h0100_0001;

    typedef struct packed {
        logic snap;
        logic mask;
        logic step;
        logic halt;
        logic en;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [DW-1:0] w);
        ctl_t c;
        c.en   = w[B_EN];
        c.halt = w[B_HALT];
        c.step = w[B_STEP];
        c.mask = w[B_MASK];
        c.snap = w[B_SNAP];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctl_to_word(input ctl_t c, input logic ready,
                                                  input logic halted);
        logic [DW-1:0] w;
        w           = '0;
        w[B_EN]     = c.en;
        w[B_HALT]   = c.halt;
        w[B_STEP]   = c.step;
        w[B_MASK]   = c.mask;
        w[B_SNAP]   = c.snap;
        w[B_READY]  = ready;
        w[B_HALTED] = halted;
        return w;
    endfunction

endpackage

// File: rtl/hdbg_ctrl.sv
module hdbg_ctrl
    import hdbg_pkg::*;
(
    input  logic clk,
    input  logic por_rst,
    input  logic warm_clr,
    input  logic wr_en,
    input  ctl_t wr_ctl,
    input  logic core_halted,
    output ctl_t ctl_q,
    output logic halted_q,
    output logic step_q
);

    logic new_halt;
    logic step_hit;

    assign new_halt = wr_ctl.en & wr_ctl.halt;
    assign step_hit = wr_ctl.en & wr_ctl.step & ~wr_ctl.halt & ctl_q.halt & halted_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctl_q    <= '0;
            halted_q <= 1'b0;
            step_q   <= 1'b0;
        end else begin
            halted_q <= core_halted;
            step_q   <= 1'b0;
            if (warm_clr) begin
                ctl_q.halt <= 1'b0;
            end else if (wr_en) begin
                ctl_q.en   <= wr_ctl.en;
                ctl_q.halt <= new_halt;
                ctl_q.step <= wr_ctl.step;
                ctl_q.mask <= wr_ctl.mask;
                ctl_q.snap <= wr_ctl.snap;
                step_q     <= step_hit;
            end
        end
    end

    a_r3_halt_needs_en: assert property (@(posedge clk) disable iff (por_rst)
        ctl_q.halt |-> ctl_q.en);

    a_r6_step_single: assert property (@(posedge clk) disable iff (por_rst)
        step_q |=> !step_q);

    a_r6_step_from_halt: assert property (@(posedge clk) disable iff (por_rst)
        step_q |-> ($past(halted_q) && $past(ctl_q.halt) && !ctl_q.halt && ctl_q.step));

    a_r5_status_tracks: assert property (@(posedge clk) disable iff (por_rst)
        !$past(por_rst) |-> (halted_q == $past(core_halted)));

    a_r9_warm_clears_halt: assert property (@(posedge clk) disable iff (por_rst)
        warm_clr |=> !ctl_q.halt);

endmodule

// File: rtl/hdbg_xfer.sv
module hdbg_xfer
    import hdbg_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             sel_wr,
    input  logic             data_wr,
    input  logic [DW-1:0]    wdata,
    input  logic             core_ack,
    input  logic [DW-1:0]    core_rdata,
    output logic             req_q,
    output logic             dir_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [DW-1:0]    data_q,
    output logic             ready_q
);

    always_ff @(posedge clk) begin
        if (por_rst) begin
            req_q   <= 1'b0;
            dir_q   <= 1'b0;
            idx_q   <= '0;
            data_q  <= '0;
            ready_q <= 1'b0;
        end else if (sel_wr) begin
            req_q   <= 1'b1;
            dir_q   <= wdata[B_DIR];
            idx_q   <= wdata[IDX_W-1:0];
            ready_q <= 1'b0;
        end else if (req_q && core_ack) begin
            req_q   <= 1'b0;
            ready_q <= 1'b1;
            if (!dir_q) data_q <= core_rdata;
        end else if (data_wr && !req_q) begin
            data_q <= wdata;
        end
    end

    a_r8_ready_on_ack: assert property (@(posedge clk) disable iff (por_rst)
        (req_q && core_ack && !sel_wr) |=> (ready_q && !req_q));

    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (por_rst)
        req_q |-> !ready_q);

endmodule

// File: rtl/hdbg_monitor.sv
module hdbg_monitor
    import hdbg_pkg::*;
(
    input  logic          clk,
    input  logic          por_rst,
    input  logic          warm_clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mon_q
);

    localparam logic [DW-1:0] KEEP_MASK = MON_WARM_MASK | MON_COLD_MASK;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            mon_q <= '0;
        end else if (warm_clr) begin
            mon_q <= mon_q & ~MON_WARM_MASK;
        end else if (wr_en) begin
            mon_q <= wdata & KEEP_MASK;
        end
    end

    a_r10_warm_clears_mon: assert property (@(posedge clk) disable iff (por_rst)
        warm_clr |=> ((mon_q & MON_WARM_MASK) == '0));

    a_r10_cold_bits_hold: assert property (@(posedge clk) disable iff (por_rst)
        warm_clr |=> ((mon_q & MON_COLD_MASK) == ($past(mon_q) & MON_COLD_MASK)));

endmodule

// File: rtl/halt_debug_unit.sv
module halt_debug_unit
    import hdbg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              vec_rst_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              core_halted,
    output logic              core_halt_req,
    output logic              core_step,
    output logic              core_xfer_req,
    output logic              core_xfer_wr,
    output logic [IDX_W-1:0]  core_xfer_idx,
    output logic [DW-1:0]     core_xfer_wdata,
    input  logic [DW-1:0]     core_xfer_rdata,
    input  logic              core_xfer_ack
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int NWORDS = 4;

    logic        warm_clr;
    logic        mapped;
    word_e       word;
    logic [NWORDS-1:0] wr_hit;
    ctl_t        ctl_q;
    logic        halted_q;
    logic        ready_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] mon_q;

    assign warm_clr = sys_rst | vec_rst_req;
    assign mapped   = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] < WORD_W'(NWORDS));
    assign word     = word_e'(bus_addr[3:2]);

    for (genvar g = 0; g < NWORDS; g++) begin : g_wr
        assign wr_hit[g] = bus_sel & bus_wr & mapped & (word == word_e'(g));
    end

    hdbg_ctrl u_ctrl (
        .clk         (clk),
        .por_rst     (por_rst),
        .warm_clr    (warm_clr),
        .wr_en       (wr_hit[WORD_CTRL]),
        .wr_ctl      (ctl_from_word(bus_wdata)),
        .core_halted (core_halted),
        .ctl_q       (ctl_q),
        .halted_q    (halted_q),
        .step_q      (core_step)
    );

    hdbg_xfer #(.IDX_W(IDX_W)) u_xfer (
        .clk        (clk),
        .por_rst    (por_rst),
        .sel_wr     (wr_hit[WORD_SEL]),
        .data_wr    (wr_hit[WORD_DATA]),
        .wdata      (bus_wdata),
        .core_ack   (core_xfer_ack),
        .core_rdata (core_xfer_rdata),
        .req_q      (core_xfer_req),
        .dir_q      (core_xfer_wr),
        .idx_q      (core_xfer_idx),
        .data_q     (data_q),
        .ready_q    (ready_q)
    );

    hdbg_monitor u_mon (
        .clk      (clk),
        .por_rst  (por_rst),
        .warm_clr (warm_clr),
        .wr_en    (wr_hit[WORD_MON]),
        .wdata    (bus_wdata),
        .mon_q    (mon_q)
    );

    assign core_halt_req   = ctl_q.en & ctl_q.halt;
    assign core_xfer_wdata = data_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && mapped) begin
            case (word)
                WORD_CTRL: bus_rdata = ctl_to_word(ctl_q, ready_q, halted_q);
                WORD_DATA: bus_rdata = data_q;
                WORD_MON:  bus_rdata = mon_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (por_rst)
        (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    a_r3_req_released: assert property (@(posedge clk) disable iff (por_rst)
        (wr_hit[WORD_CTRL] && !warm_clr && !bus_wdata[B_EN]) |=> !core_halt_req);

endmodule

// File: tb/halt_debug_unit_bench.sv
module halt_debug_unit_bench;

    localparam int PERIOD = 10;
    localparam int AW = 5;
    localparam int IW = 5;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [31:0]   w;
        logic [31:0]   e;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{5'h00, 32'h0000_0002, 32'h0000_0000},  // R4 halt without enable
        '{5'h00, 32'h0000_002D, 32'h0000_002D},  // R3 plain bits
        '{5'h00, 32'hFFFF_FFFF, 32'h0000_002F},  // R11 read-only fields
        '{5'h0C, 32'hFFFF_FFFF, 32'h010F_0001},  // R10 field mask
        '{5'h14, 32'h1234_5678, 32'h0000_0000},  // R11 unmapped
        '{5'h0E, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 misaligned
        '{5'h00, 32'h0000_0000, 32'h0000_0000}   // R3 clear
    };

    logic clk = 1'b0;
    logic por_rst = 1'b1, sys_rst = 1'b0, vec_rst_req = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic core_halted = 1'b0, core_halt_req, core_step;
    logic core_xfer_req, core_xfer_wr, core_xfer_ack = 1'b0;
    logic [IW-1:0] core_xfer_idx;
    logic [31:0] core_xfer_wdata, core_xfer_rdata = '0;

    int n_chk = 0, n_fail = 0, step_cnt = 0;
    logic [31:0] rd;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;
    always @(negedge clk) if (core_step) step_cnt++;

    halt_debug_unit #(.ADDR_W(AW), .IDX_W(IW)) u_halt_debug_unit (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .vec_rst_req(vec_rst_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_halted(core_halted), .core_halt_req(core_halt_req), .core_step(core_step),
        .core_xfer_req(core_xfer_req), .core_xfer_wr(core_xfer_wr),
        .core_xfer_idx(core_xfer_idx), .core_xfer_wdata(core_xfer_wdata),
        .core_xfer_rdata(core_xfer_rdata), .core_xfer_ack(core_xfer_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); core_xfer_ack = 1'b1;
        @(negedge clk); core_xfer_ack = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        // R2 reset state
        rdw(5'h00, rd); check("R2 ctrl", rd, 32'h0);
        rdw(5'h0C, rd); check("R2 mon", rd, 32'h0);
        rdw(5'h08, rd); check("R2 data", rd, 32'h0);
        check("R2 halt_req", {31'b0, core_halt_req}, 32'h0);

        // table walk (R1 R3 R4 R10 R11)
        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].a, TBL[i].w);
            rdw(TBL[i].a, rd);
            check($sformatf("R1 table %0d", i), rd, TBL[i].e);
        end
        rdw(5'h04, rd); check("R1 select reads zero", rd, 32'h0);

        // R3 halt request and R5 halted flag
        wr(5'h00, 32'h3);
        check("R3 halt_req", {31'b0, core_halt_req}, 32'h1);
        @(negedge clk); core_halted = 1'b1;
        @(negedge clk);
        rdw(5'h00, rd); check("R5 halted set", rd, 32'h0002_0003);

        // R6 single step
        wr(5'h00, 32'h7);
        step_cnt = 0;
        wr(5'h00, 32'h5);
        @(negedge clk); @(negedge clk);
        check("R6 one step pulse", step_cnt, 1);
        check("R3 halt dropped", {31'b0, core_halt_req}, 32'h0);
        core_halted = 1'b0;
        @(negedge clk);
        rdw(5'h00, rd); check("R5 halted clears", rd, 32'h0000_0005);
        core_halted = 1'b1;
        @(negedge clk);
        wr(5'h00, 32'h3);
        rdw(5'h00, rd); check("R5 re-halted", rd, 32'h0002_0003);

        // resume without step bit: no pulse
        wr(5'h00, 32'h1);
        @(negedge clk); @(negedge clk);
        check("R6 no pulse on resume", step_cnt, 1);
        core_halted = 1'b0;
        // step bit set but not halted: no pulse
        wr(5'h00, 32'h3);
        wr(5'h00, 32'h5);
        @(negedge clk); @(negedge clk);
        check("R6 no pulse when running", step_cnt, 1);

        // R7/R8 write transfer
        wr(5'h08, 32'hA5A5_0001);
        wr(5'h04, 32'h0001_0003);
        check("R7 req", {31'b0, core_xfer_req}, 32'h1);
        check("R7 dir write", {31'b0, core_xfer_wr}, 32'h1);
        check("R7 idx", {27'b0, core_xfer_idx}, 32'h3);
        check("R8 wdata", core_xfer_wdata, 32'hA5A5_0001);
        rdw(5'h00, rd); check("R7 ready low", rd & 32'h0001_0000, 32'h0);
        pulse_ack();
        check("R8 req drops", {31'b0, core_xfer_req}, 32'h0);
        rdw(5'h00, rd); check("R8 ready high", rd & 32'h0001_0000, 32'h0001_0000);

        // R7/R8 read transfer
        core_xfer_rdata = 32'h1234_ABCD;
        wr(5'h04, 32'h0000_0007);
        check("R7 dir read", {31'b0, core_xfer_wr}, 32'h0);
        check("R7 idx 7", {27'b0, core_xfer_idx}, 32'h7);
        pulse_ack();
        rdw(5'h08, rd); check("R8 read data", rd, 32'h1234_ABCD);

        // R9/R10 system reset
        wr(5'h00, 32'h2F);
        wr(5'h0C, 32'h010F_0001);
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
        rdw(5'h00, rd); check("R9 sys ctrl", rd, 32'h0001_002D);
        rdw(5'h0C, rd); check("R10 sys mon", rd, 32'h0100_0001);

        // R9/R10 vector reset, write in same cycle dropped
        wr(5'h00, 32'h2F);
        wr(5'h0C, 32'h010F_0001);
        @(negedge clk);
        vec_rst_req = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h0;
        @(negedge clk);
        vec_rst_req = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rdw(5'h00, rd); check("R9 vec ctrl", rd, 32'h0001_002D);
        rdw(5'h0C, rd); check("R10 vec mon", rd, 32'h0100_0001);

        // R2 power-on reset
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); por_rst = 1'b0;
        rdw(5'h00, rd); check("R2 por ctrl", rd, 32'h0);
        rdw(5'h0C, rd); check("R2 por mon", rd, 32'h0);
        rdw(5'h08, rd); check("R2 por data", rd, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1'b1;
        $finish;
    end

endmodule